// File: doc/BRIEF.md
# Link Training Reset Sequencer

This block holds a serial link's reset chain asserted until the device has finished configuring and the transceiver has finished calibrating, and then lets the resets go one at a time in a fixed order. The first reset released is the one for the transceiver reconfiguration manager. The near-side (endpoint) reset follows once calibration is idle and a short minimum delay has passed. The far-side (root port) reset is released after a long second delay. The application layer reset comes last. A done flag then reports that the chain is fully released.

The configuration-done input and both calibration-busy inputs may arrive from other clock domains, so each passes through a two-stage synchronizer first. Both delays are given in microseconds and converted to clock cycles from a clock-frequency parameter. The default gives 1 ms and 100 ms at 100 MHz. A bench can choose small values. If configuration is lost at any point, the whole chain reasserts and the sequence starts again from the beginning.

Top module: `link_rst_seq`

## Requirements
- R1: While `rst` is high, or while the synchronized configuration-done input is low, all four reset outputs are 1 and `seq_done_o` is 0.
- R2: When `cfg_done_i` goes high, `rcfg_rst_o` goes to 0 after the third rising clock edge that follows. The endpoint, root-port and application resets stay at 1 at that point.
- R3: `ep_rst_o` stays at 1 for as long as either `tx_cal_busy_i` or `rx_cal_busy_i` is 1, as seen through the two-stage synchronizer.
- R4: `ep_rst_o` goes to 0 on the first clock edge at which both of these hold: at least EP_CYC cycles have passed since `rcfg_rst_o` went to 0, and both synchronized busy inputs are 0. EP_CYC = (CLK_HZ / 1,000,000) × EP_WAIT_US, with a minimum of 1.
- R5: `rp_rst_o` goes to 0 exactly RP_CYC cycles after `ep_rst_o` goes to 0. RP_CYC = (CLK_HZ / 1,000,000) × RP_WAIT_US, with a minimum of 1.
- R6: `app_rst_o` goes to 0 one cycle after `rp_rst_o` goes to 0. `seq_done_o` goes to 1 on the same edge.
- R7: When `cfg_done_i` goes low, all four resets are 1 and `seq_done_o` is 0 after the third rising edge that follows, whatever the current stage. When the input returns high, the sequence restarts at R2.
- R8: Once set, `seq_done_o` stays at 1 until configuration-done is lost or `rst` is asserted.
- R9: No reset output is at 0 while the reset before it in the order reconfiguration, endpoint, root port, application is at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done_i | input | 1 | Device configuration complete (asynchronous) |
| tx_cal_busy_i | input | 1 | Transmit calibration in progress (asynchronous) |
| rx_cal_busy_i | input | 1 | Receive calibration in progress (asynchronous) |
| rcfg_rst_o | output | 1 | Reset to the reconfiguration manager, active high |
| ep_rst_o | output | 1 | Endpoint reset, active high |
| rp_rst_o | output | 1 | Root-port reset, active high |
| app_rst_o | output | 1 | Application-layer reset, active high |
| seq_done_o | output | 1 | High once the whole chain is released |

## Verification
The timing properties assume that each input level is captured on the clock and reaches the state machine exactly three edges later. They also assume that no input changes within a single edge's setup window. The bench respects both assumptions by changing inputs only on falling edges, so every level is captured cleanly by the first synchronizer stage. The release-delay properties also assume that configuration-done stays high for the whole wait being checked. To cover restarts, the bench deliberately drops configuration-done during the long wait and after completion, including a single-cycle glitch.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CAL  = 3'd1,
        ST_RPW  = 3'd2,
        ST_RPUP = 3'd3,
        ST_RUN  = 3'd4
    } lrs_state_e;

    typedef struct packed {
        logic cfg;
        logic tx_busy;
        logic rx_busy;
    } lrs_in_t;

    typedef struct packed {
        logic rcfg;
        logic ep;
        logic rp;
        logic app;
        logic done;
    } lrs_out_t;

    localparam lrs_out_t OUT_HELD = '{rcfg: 1'b1, ep: 1'b1, rp: 1'b1, app: 1'b1, done: 1'b0};

    function automatic int unsigned us_to_cycles(longint unsigned hz, int unsigned us);
        longint unsigned c;
        c = (hz / 64'd1_000_000) * longint'(us);
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic lrs_out_t decode_state(lrs_state_e st);
        lrs_out_t o;
        o.rcfg = (st == ST_IDLE);
        o.ep   = (st == ST_IDLE) || (st == ST_CAL);
        o.rp   = (st != ST_RPUP) && (st != ST_RUN);
        o.app  = (st != ST_RUN);
        o.done = (st == ST_RUN);
        return o;
    endfunction

endpackage

// File: rtl/lrs_sync.sv
module lrs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lrs_timer.sv
module lrs_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr_i)         cnt_o <= '0;
        else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
    import lrs_pkg::*;
#(
    parameter int          CW     = 8,
    parameter int unsigned EP_CYC = 4,
    parameter int unsigned RP_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  lrs_in_t       in_s,
    input  logic [CW-1:0] cnt_i,
    output logic          clr_o,
    output lrs_out_t      out_o
);
    localparam logic [CW-1:0] EP_LIM = CW'(EP_CYC - 1);
    localparam logic [CW-1:0] RP_LIM = CW'(RP_CYC - 1);

    lrs_state_e state_q, state_n;
    logic       cal_idle;

    assign cal_idle = !in_s.tx_busy && !in_s.rx_busy;

    always_comb begin
        state_n = state_q;
        if (!in_s.cfg) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_n = ST_CAL;
                ST_CAL:  if (cal_idle && cnt_i >= EP_LIM) state_n = ST_RPW;
                ST_RPW:  if (cnt_i >= RP_LIM) state_n = ST_RPUP;
                ST_RPUP: state_n = ST_RUN;
                ST_RUN:  state_n = ST_RUN;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    assign clr_o = (state_n != state_q) || (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            out_o   <= OUT_HELD;
        end else begin
            state_q <= state_n;
            out_o   <= decode_state(state_n);
        end
    end
endmodule

// File: rtl/link_rst_seq.sv
module link_rst_seq
    import lrs_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned     EP_WAIT_US = 1000,
    parameter int unsigned     RP_WAIT_US = 100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_done_i,
    input  logic tx_cal_busy_i,
    input  logic rx_cal_busy_i,
    output logic rcfg_rst_o,
    output logic ep_rst_o,
    output logic rp_rst_o,
    output logic app_rst_o,
    output logic seq_done_o
);
    localparam int unsigned EP_CYC  = us_to_cycles(CLK_HZ, EP_WAIT_US);
    localparam int unsigned RP_CYC  = us_to_cycles(CLK_HZ, RP_WAIT_US);
    localparam int unsigned MAX_CYC = (EP_CYC > RP_CYC) ? EP_CYC : RP_CYC;
    localparam int          CW      = $clog2(MAX_CYC + 1);
    localparam int          IW      = $bits(lrs_in_t);

    lrs_in_t       raw_in;
    logic [IW-1:0] sync_q;
    lrs_in_t       sync_in;
    logic [CW-1:0] cnt;
    logic          cnt_clr;
    lrs_out_t      outs;

    assign raw_in = '{cfg: cfg_done_i, tx_busy: tx_cal_busy_i, rx_busy: rx_cal_busy_i};

    lrs_sync #(.W(IW), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (sync_q)
    );

    assign sync_in = lrs_in_t'(sync_q);

    lrs_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr_i (cnt_clr),
        .cnt_o (cnt)
    );

    lrs_fsm #(.CW(CW), .EP_CYC(EP_CYC), .RP_CYC(RP_CYC)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .in_s  (sync_in),
        .cnt_i (cnt),
        .clr_o (cnt_clr),
        .out_o (outs)
    );

    assign rcfg_rst_o = outs.rcfg;
    assign ep_rst_o   = outs.ep;
    assign rp_rst_o   = outs.rp;
    assign app_rst_o  = outs.app;
    assign seq_done_o = outs.done;
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk #(
    parameter int unsigned EP_CYC = 4,
    parameter int unsigned RP_CYC = 8
) (
    input logic clk,
    input logic rst,
    input logic cfg_done_i,
    input logic tx_cal_busy_i,
    input logic rx_cal_busy_i,
    input logic rcfg_rst_o,
    input logic ep_rst_o,
    input logic rp_rst_o,
    input logic app_rst_o,
    input logic seq_done_o
);
    logic [31:0] since_rcfg, since_ep;

    always_ff @(posedge clk) begin
        if (rst || rcfg_rst_o)     since_rcfg <= '0;
        else if (~&since_rcfg)     since_rcfg <= since_rcfg + 1;
        if (rst || ep_rst_o)       since_ep <= '0;
        else if (~&since_ep)       since_ep <= since_ep + 1;
    end

    AST_IDLE_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_done_i, 3) |-> (rcfg_rst_o && ep_rst_o && rp_rst_o && app_rst_o && !seq_done_o)); // R7

    AST_EP_AFTER_RCFG: assert property (@(posedge clk) disable iff (rst)
        !ep_rst_o |-> !rcfg_rst_o); // R9
    AST_RP_AFTER_EP: assert property (@(posedge clk) disable iff (rst)
        !rp_rst_o |-> !ep_rst_o); // R9
    AST_APP_AFTER_RP: assert property (@(posedge clk) disable iff (rst)
        !app_rst_o |-> !rp_rst_o); // R9

    AST_EP_CAL_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(ep_rst_o) |-> (!$past(tx_cal_busy_i, 3) && !$past(rx_cal_busy_i, 3))); // R3
    AST_EP_MIN_WAIT: assert property (@(posedge clk) disable iff (rst)
        $fell(ep_rst_o) |-> (since_rcfg >= EP_CYC)); // R4
    AST_RP_WAIT: assert property (@(posedge clk) disable iff (rst)
        $fell(rp_rst_o) |-> (since_ep == RP_CYC)); // R5
    AST_APP_NEXT: assert property (@(posedge clk) disable iff (rst)
        $fell(app_rst_o) |-> ($past(!rp_rst_o) && seq_done_o)); // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(seq_done_o) && $past(cfg_done_i, 3)) |-> seq_done_o); // R8
endmodule

bind link_rst_seq lrs_chk #(.EP_CYC(EP_CYC), .RP_CYC(RP_CYC)) u_lrs_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_done_i    (cfg_done_i),
    .tx_cal_busy_i (tx_cal_busy_i),
    .rx_cal_busy_i (rx_cal_busy_i),
    .rcfg_rst_o    (rcfg_rst_o),
    .ep_rst_o      (ep_rst_o),
    .rp_rst_o      (rp_rst_o),
    .app_rst_o     (app_rst_o),
    .seq_done_o    (seq_done_o)
);

// File: tb/test_link_rst_seq.sv
module test_link_rst_seq;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned T_HZ = 1_000_000;
    localparam int EP = 12;
    localparam int RP = 30;

    logic clk = 1'b0;
    logic rst, cfg, tx, rx;
    logic rcfg_r, ep_r, rp_r, app_r, done;
    int   n_chk = 0, n_fail = 0;
    bit   cmp_en = 0, finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_rst_seq #(.CLK_HZ(T_HZ), .EP_WAIT_US(EP), .RP_WAIT_US(RP)) i_link_rst_seq (
        .clk(clk), .rst(rst), .cfg_done_i(cfg), .tx_cal_busy_i(tx), .rx_cal_busy_i(rx),
        .rcfg_rst_o(rcfg_r), .ep_rst_o(ep_r), .rp_rst_o(rp_r), .app_rst_o(app_r), .seq_done_o(done)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, got, exp);
        end
    endtask

    // Behavioural reference: input history queue, stage number, elapsed cycles
    logic [2:0] hist[$];
    int ph = 0, el = 0;
    always @(posedge clk) begin
        logic [2:0] v;
        if (rst) begin
            hist = {3'b000, 3'b000};
            ph = 0; el = 0;
        end else begin
            v = hist.pop_front();
            hist.push_back({cfg, tx, rx});
            if (!v[2]) begin ph = 0; el = 0; end
            else case (ph)
                0: begin ph = 1; el = 0; end
                1: if (el >= EP-1 && !v[1] && !v[0]) begin ph = 2; el = 0; end else el++;
                2: if (el >= RP-1) begin ph = 3; el = 0; end else el++;
                3: ph = 4;
                default: ph = 4;
            endcase
        end
    end

    always @(negedge clk) if (cmp_en) begin
        chk("R2 rcfg vs model", rcfg_r, ph == 0);
        chk("R4 ep vs model",   ep_r,   ph < 2);
        chk("R5 rp vs model",   rp_r,   ph < 3);
        chk("R6 app vs model",  app_r,  ph < 4);
        chk("R8 done vs model", done,   ph == 4);
        chk("R9 order", (!ep_r && rcfg_r) || (!rp_r && ep_r) || (!app_r && rp_r), 0);
    end

    function automatic logic pick(int w);
        case (w)
            0: return rcfg_r;
            1: return ep_r;
            2: return rp_r;
            default: return app_r;
        endcase
    endfunction

    // number of falling edges until output w reaches level val
    task automatic wait_lvl(int w, logic val, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (pick(w) != val && n < 2000);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1; cfg = 0; tx = 1; rx = 1;
        @(negedge clk); cmp_en = 1;
        repeat (3) @(negedge clk);
        chk("R1 reset rcfg", rcfg_r, 1); chk("R1 reset app", app_r, 1); chk("R1 reset done", done, 0);
        rst = 0;
        repeat (5) @(negedge clk);
        chk("R1 no cfg ep", ep_r, 1); chk("R1 no cfg rp", rp_r, 1);

        // A: calibration outlasts the minimum wait
        cfg = 1;
        wait_lvl(0, 0, n); chk("R2 rcfg latency", n, 3); chk("R2 ep still held", ep_r, 1);
        repeat (25) @(negedge clk); chk("R3 ep held while both busy", ep_r, 1);
        tx = 0; repeat (5) @(negedge clk); chk("R3 ep held while rx busy", ep_r, 1);
        rx = 0;
        wait_lvl(1, 0, n); chk("R4 ep after busy clears", n, 3);
        wait_lvl(2, 0, n); chk("R5 rp delay", n, RP);
        wait_lvl(3, 0, n); chk("R6 app one later", n, 1); chk("R6 done with app", done, 1);
        repeat (20) @(negedge clk); chk("R8 done holds", done, 1);

        // B: loss after completion, then restart governed by the timer, drop mid-wait
        cfg = 0;
        wait_lvl(0, 1, n); chk("R7 drop latency", n, 3);
        chk("R7 all held", {ep_r, rp_r, app_r}, 3'b111); chk("R7 done cleared", done, 0);
        repeat (4) @(negedge clk);
        cfg = 1;
        wait_lvl(0, 0, n); chk("R2 restart latency", n, 3);
        wait_lvl(1, 0, n); chk("R4 timer governs", n, EP);
        repeat (10) @(negedge clk);
        cfg = 0;
        repeat (3) @(negedge clk);
        chk("R7 drop in long wait", {rcfg_r, ep_r, rp_r, app_r}, 4'b1111);

        // C: short transmit calibration inside the minimum wait
        repeat (4) @(negedge clk);
        cfg = 1; tx = 1;
        repeat (5) @(negedge clk); tx = 0;
        wait_lvl(1, 0, n); chk("R4 short busy hidden by timer", n + 5, 3 + EP);
        wait_lvl(3, 0, n); chk("R6 chain completes", done, 1);

        // D: single-cycle glitch on configuration-done
        repeat (3) @(negedge clk);
        cfg = 0; @(negedge clk); cfg = 1;
        repeat (2) @(negedge clk);
        chk("R7 glitch reasserts", {rcfg_r, ep_r, app_r, done}, 4'b1110);
        @(negedge clk);
        chk("R7 glitch restarts rcfg", rcfg_r, 0); chk("R7 glitch restarts ep held", ep_r, 1);
        repeat (EP + RP + 6) @(negedge clk);
        chk("R8 done after restart", done, 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule